// File: doc/BRIEF.md
# Rotating Row-Bank Crossbar

This block keeps a small set of line buffers, each holding one image row of 16-bit pixel words, and presents them to the row inputs of a convolution cluster. Output row 0 is always the top row of the current window, output row 1 the one below it, and so on down to the configured window height. Every output row shows the word at the same column index, selected by `rd_col`, so the cluster sees one vertical slice of the window in each cycle.

After a reset or a change of window height, the block accepts rows over a valid/ready write stream until the window is full. A shift-down command then drops the top row. The physical bank that held that row is reused for the next incoming row, which becomes the bottom row. Only a rotation pointer moves and no stored word is copied. The crossbar maps output i to bank (pointer + i) modulo the height.

Back-pressure rules for the write stream: a word moves on a rising clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` never depends on `wr_valid`. The writer may hold `wr_valid` and `wr_data` for as long as it likes. `wr_ready` is high only while a row is pending, so it is low whenever the window is full. The words of one row arrive in column order, from column 0 to the last column.

Top module: `rowbank_xbar`

## Requirements
- R1: While reset is asserted, `row_ready` is low, every `rd_active` bit is low and every output word is zero.
- R2: A write word is accepted only on an edge with `wr_valid` and `wr_ready` both high. `wr_ready` is high exactly when a row is pending and the height in use equals the requested height. A word offered while `wr_ready` is low changes nothing.
- R3: After reset or a restart, the first H rows received fill output rows 0 to H-1 in arrival order. Output row k becomes active in the cycle after the last word of the (k+1)-th row is accepted.
- R4: `row_ready` is high exactly when all H rows of the window are complete. It rises only in the cycle after the last word of a row is accepted.
- R5: For every active output row i, `rd_data` bits [16i+15:16i] show, combinationally, the word at column `rd_col` of window row i.
- R6: A `shift_req` seen on an edge while `row_ready` is high discards the top row. In the next cycle, output row i shows the former row i+1, `row_ready` is low and `wr_ready` is high. The next row received becomes row H-1.
- R7: An output row that is inside the height but is not complete, such as row H-1 during a refill, has its `rd_active` bit low and its word forced to zero.
- R8: Output rows at index H or above are always inactive and zero.
- R9: A `shift_req` while `row_ready` is low has no effect.
- R10: A `cfg_height` of 0 acts as 1, and values above the bank count act as the bank count. When the requested height differs from the height in use, the next edge clears the window and restarts the load.
- R11: A `rd_col` at or above the row length gives zero on every output row.
- R12: With a height of 1, a shift refills the single bank. The row is inactive until the new row is complete and then shows the new words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_height | input | 3 | Requested window height in rows (0 acts as 1) |
| shift_req | input | 1 | Move the window down one row |
| wr_valid | input | 1 | Write stream: word offered |
| wr_ready | output | 1 | Write stream: a row is pending and a word can be taken |
| wr_data | input | 16 | Write stream: pixel word |
| rd_col | input | 3 | Column read from every bank |
| rd_data | output | 112 | Seven output rows of 16 bits, row i at bits [16i+15:16i] |
| rd_active | output | 7 | Per-output-row flag: row holds complete data |
| row_ready | output | 1 | The whole window is complete |

## Verification
The bench goes after the wrap of the rotation pointer for heights 3, 7 and 1. A design that computes the modulo wrongly would show rows out of order after the second shift. It checks that the refilled row stays dark until its last word lands. A design without that exclusion would leak the stale top row onto output H-1. It also sends shifts during a refill, holds writes against a full window, changes the height mid-refill and sweeps columns past the row end. A design that got one of these wrong would drop or double a row, corrupt a bank, keep stale rows or read beyond the row.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  // Maps a requested window height onto the supported range 1..max_rows.
  function automatic int clamp_rows(input int req, input int max_rows);
    if (req < 1) return 1;
    if (req > max_rows) return max_rows;
    return req;
  endfunction
endpackage

// File: rtl/rbx_bank.sv
module rbx_bank #(
  parameter int WORD_W = 16,
  parameter int ROW_LEN = 6,
  parameter int CW = 3
) (
  input  logic              clk,
  input  logic              we,
  input  logic [CW-1:0]     wcol,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CW-1:0]     rcol,
  output logic [WORD_W-1:0] rword
);
  localparam int DEPTH = 1 << CW;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wcol] <= wdata;
  end

  // columns past the row end read as zero
  assign rword = (int'(rcol) < ROW_LEN) ? mem[rcol] : '0;
endmodule

// File: rtl/rbx_ctrl.sv
module rbx_ctrl #(
  parameter int MAX_ROWS = 7,
  parameter int ROW_LEN = 6,
  parameter int HW = 3,
  parameter int PW = 3,
  parameter int CW = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HW-1:0]       cfg_height,
  input  logic                shift_req,
  input  logic                wr_valid,
  output logic                wr_ready,
  output logic                row_ready,
  output logic                wr_en,
  output logic [PW-1:0]       wr_bank,
  output logic [CW-1:0]       wr_col,
  output logic [PW-1:0]       ptr,
  output logic [HW-1:0]       height,
  output logic [MAX_ROWS-1:0] row_on
);
  logic [HW-1:0] h_eff, height_q, cnt_q;
  logic [PW-1:0] ptr_q, ptr_nxt, fill_q;
  logic [CW-1:0] col_q;
  logic          loading_q, refill_q;
  logic          restart, filling, last_col, shift_fire;

  assign h_eff      = HW'(rbx_pkg::clamp_rows(int'(cfg_height), MAX_ROWS));
  assign restart    = (h_eff != height_q);
  assign filling    = loading_q | refill_q;
  assign wr_ready   = filling & ~restart;
  assign row_ready  = ~filling;
  assign wr_en      = wr_valid & wr_ready;
  assign last_col   = (col_q == CW'(ROW_LEN - 1));
  assign shift_fire = shift_req & ~filling & ~restart;
  assign ptr_nxt    = (HW'(ptr_q) + HW'(1) == height_q) ? '0 : ptr_q + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      height_q  <= HW'(1);
      loading_q <= 1'b1;
      refill_q  <= 1'b0;
      cnt_q     <= '0;
      col_q     <= '0;
      fill_q    <= '0;
      ptr_q     <= '0;
    end else if (restart) begin
      height_q  <= h_eff;
      loading_q <= 1'b1;
      refill_q  <= 1'b0;
      cnt_q     <= '0;
      col_q     <= '0;
      fill_q    <= '0;
      ptr_q     <= '0;
    end else if (wr_en) begin
      if (last_col) begin
        col_q <= '0;
        if (loading_q) begin
          if (cnt_q + HW'(1) == height_q) loading_q <= 1'b0;
          cnt_q  <= cnt_q + HW'(1);
          fill_q <= fill_q + PW'(1);
        end else begin
          refill_q <= 1'b0;
        end
      end else begin
        col_q <= col_q + CW'(1);
      end
    end else if (shift_fire) begin
      refill_q <= 1'b1;
      fill_q   <= ptr_q;
      ptr_q    <= ptr_nxt;
    end
  end

  // window row i is live when inside the height and its data is complete
  for (genvar i = 0; i < MAX_ROWS; i++) begin : g_on
    always_comb begin
      if (HW'(i) >= height_q) row_on[i] = 1'b0;
      else if (loading_q)     row_on[i] = (HW'(i) < cnt_q);
      else                    row_on[i] = !(refill_q && (HW'(i) + HW'(1) == height_q));
    end
  end

  assign wr_bank = fill_q;
  assign wr_col  = col_q;
  assign ptr     = ptr_q;
  assign height  = height_q;
endmodule

// File: rtl/rbx_xbar.sv
module rbx_xbar #(
  parameter int MAX_ROWS = 7,
  parameter int WORD_W = 16,
  parameter int PW = 3,
  parameter int HW = 3
) (
  input  logic [MAX_ROWS*WORD_W-1:0] bank_words,
  input  logic [PW-1:0]              ptr,
  input  logic [HW-1:0]              height,
  input  logic [MAX_ROWS-1:0]        row_on,
  output logic [MAX_ROWS*WORD_W-1:0] rd_data,
  output logic [MAX_ROWS-1:0]        rd_active
);
  localparam int SW = HW + 1;

  for (genvar i = 0; i < MAX_ROWS; i++) begin : g_out
    logic [SW-1:0] sum, idx;
    always_comb begin
      sum = SW'(ptr) + SW'(i);
      idx = (sum >= SW'(height)) ? sum - SW'(height) : sum;
    end
    assign rd_data[i*WORD_W +: WORD_W] = row_on[i] ? bank_words[idx*WORD_W +: WORD_W] : '0;
    assign rd_active[i] = row_on[i];
  end
endmodule

// File: rtl/rowbank_xbar.sv
module rowbank_xbar #(
  parameter int MAX_ROWS = 7,
  parameter int WORD_W = 16,
  parameter int ROW_LEN = 6,
  localparam int HW = $clog2(MAX_ROWS + 1),
  localparam int PW = (MAX_ROWS > 1) ? $clog2(MAX_ROWS) : 1,
  localparam int CW = (ROW_LEN > 1) ? $clog2(ROW_LEN) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [HW-1:0]              cfg_height,
  input  logic                       shift_req,
  input  logic                       wr_valid,
  output logic                       wr_ready,
  input  logic [WORD_W-1:0]          wr_data,
  input  logic [CW-1:0]              rd_col,
  output logic [MAX_ROWS*WORD_W-1:0] rd_data,
  output logic [MAX_ROWS-1:0]        rd_active,
  output logic                       row_ready
);
  logic                       wr_en;
  logic [PW-1:0]              wr_bank, ptr;
  logic [CW-1:0]              wr_col;
  logic [HW-1:0]              height;
  logic [MAX_ROWS-1:0]        row_on;
  logic [MAX_ROWS*WORD_W-1:0] bank_words;

  rbx_ctrl #(
    .MAX_ROWS(MAX_ROWS), .ROW_LEN(ROW_LEN), .HW(HW), .PW(PW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_height(cfg_height), .shift_req(shift_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .row_ready(row_ready),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_col(wr_col), .ptr(ptr),
    .height(height), .row_on(row_on)
  );

  for (genvar b = 0; b < MAX_ROWS; b++) begin : g_bank
    rbx_bank #(.WORD_W(WORD_W), .ROW_LEN(ROW_LEN), .CW(CW)) u_bank (
      .clk(clk),
      .we(wr_en && (wr_bank == PW'(b))),
      .wcol(wr_col),
      .wdata(wr_data),
      .rcol(rd_col),
      .rword(bank_words[b*WORD_W +: WORD_W])
    );
  end

  rbx_xbar #(.MAX_ROWS(MAX_ROWS), .WORD_W(WORD_W), .PW(PW), .HW(HW)) u_xbar (
    .bank_words(bank_words), .ptr(ptr), .height(height), .row_on(row_on),
    .rd_data(rd_data), .rd_active(rd_active)
  );
endmodule

// File: rtl/rowbank_xbar_chk.sv
module rowbank_xbar_chk #(
  parameter int MAX_ROWS = 7,
  parameter int WORD_W = 16,
  parameter int HW = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [HW-1:0]              cfg_height,
  input logic                       shift_req,
  input logic                       wr_valid,
  input logic                       wr_ready,
  input logic [MAX_ROWS*WORD_W-1:0] rd_data,
  input logic [MAX_ROWS-1:0]        rd_active,
  input logic                       row_ready
);
  // R2
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && row_ready));

  // R4
  row_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(row_ready) |-> $past(wr_valid && wr_ready));

  // R6
  shift_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_req && row_ready) |=> !row_ready);

  // R9
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_req && wr_ready && !wr_valid) |=> ($stable(rd_active) && !row_ready));

  for (genvar i = 0; i < MAX_ROWS; i++) begin : g_row
    // R8
    beyond_height_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(cfg_height) && (i >= rbx_pkg::clamp_rows(int'(cfg_height), MAX_ROWS)))
        |-> !rd_active[i]);

    // R7
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_active[i] |-> (rd_data[i*WORD_W +: WORD_W] == '0));
  end
endmodule

bind rowbank_xbar rowbank_xbar_chk #(.MAX_ROWS(MAX_ROWS), .WORD_W(WORD_W), .HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_height(cfg_height), .shift_req(shift_req),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
  .rd_active(rd_active), .row_ready(row_ready)
);

// File: tb/rowbank_xbar_bench.sv
`timescale 1ns/1ps
module rowbank_xbar_bench;
  localparam int MAXR = 7;
  localparam int WW = 16;
  localparam int RL = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_height = 3'd3;
  logic shift_req = 1'b0;
  logic wr_valid = 1'b0;
  logic [WW-1:0] wr_data = '0;
  logic [2:0] rd_col = '0;
  logic wr_ready, row_ready;
  logic [MAXR*WW-1:0] rd_data;
  logic [MAXR-1:0] rd_active;

  int n_tests = 0;
  int n_fail = 0;

  rowbank_xbar u_rowbank_xbar (
    .clk(clk), .rst_n(rst_n), .cfg_height(cfg_height), .shift_req(shift_req),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .rd_col(rd_col),
    .rd_data(rd_data), .rd_active(rd_active), .row_ready(row_ready)
  );

  always #2 clk = ~clk;

  // reference model: queue of complete window rows, top row first
  typedef logic [RL*WW-1:0] row_t;
  row_t win[$];
  row_t pend;
  int m_col = 0;
  int m_h = 1;

  function automatic int heff(input logic [2:0] c);
    if (c == 0) return 1;
    if (int'(c) > MAXR) return MAXR;
    return int'(c);
  endfunction

  function automatic bit m_wr_ready();
    return (heff(cfg_height) == m_h) && (win.size() < m_h);
  endfunction

  function automatic bit m_row_ready();
    return win.size() == m_h;
  endfunction

  function automatic logic [WW-1:0] row_word(input row_t r);
    if (int'(rd_col) >= RL) return '0;
    return r[int'(rd_col)*WW +: WW];
  endfunction

  function automatic logic [WW-1:0] m_data(input int i);
    if (i >= win.size()) return '0;
    return row_word(win[i]);
  endfunction

  function automatic logic [WW-1:0] pix(input int seed, input int c);
    return 16'h8000 | WW'((seed * 64 + c * 5 + 3) & 16'h7fff);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      win.delete(); m_col = 0; m_h = 1;
    end else if (heff(cfg_height) != m_h) begin
      m_h = heff(cfg_height); win.delete(); m_col = 0;
    end else if (wr_valid && m_wr_ready()) begin
      pend[m_col*WW +: WW] = wr_data;
      m_col++;
      if (m_col == RL) begin win.push_back(pend); m_col = 0; end
    end else if (shift_req && m_row_ready()) begin
      void'(win.pop_front());
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    check(row_ready === m_row_ready(), "R4", longint'(row_ready), longint'(m_row_ready()));
    check(wr_ready === m_wr_ready(), "R2", longint'(wr_ready), longint'(m_wr_ready()));
    for (int i = 0; i < MAXR; i++) begin
      string tag;
      logic [WW-1:0] got;
      bit exp_act;
      got = rd_data[i*WW +: WW];
      exp_act = (i < win.size());
      if (i >= m_h) tag = "R8";
      else if (int'(rd_col) >= RL) tag = "R11";
      else if (exp_act) tag = "R5";
      else tag = "R7";
      check(rd_active[i] === exp_act, tag, longint'(rd_active[i]), longint'(exp_act));
      check(got === m_data(i), tag, longint'(got), longint'(m_data(i)));
    end
  endtask

  // compare every cycle, 1 ns after the falling edge
  always begin
    @(negedge clk);
    #1;
    compare();
  end

  // column sweep, including columns past the row end
  initial begin
    forever begin
      @(negedge clk);
      rd_col = rd_col + 3'd1;
    end
  end

  task automatic send_row(input int seed, input int gap);
    for (int c = 0; c < RL; c++) begin
      @(negedge clk);
      if (gap > 0 && (c % 2 == 1)) begin
        wr_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      wr_valid = 1'b1;
      wr_data = pix(seed, c);
      while (!wr_ready) @(negedge clk);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_shift();
    @(negedge clk); shift_req = 1'b1;
    @(negedge clk); shift_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    row_t saved;
    logic [MAXR-1:0] act_before;
    logic [WW-1:0] exp_w;

    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    check(row_ready == 1'b0, "R1", longint'(row_ready), 0);
    check(rd_active == '0, "R1", longint'(rd_active), 0);
    check(rd_data == '0, "R1", 1, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3 initial load, height 3
    for (int k = 0; k < 3; k++) begin
      send_row(k, k % 2);
      #1;
      check(rd_active == MAXR'((1 << (k + 1)) - 1), "R3", longint'(rd_active), (1 << (k + 1)) - 1);
    end
    check(row_ready == 1'b1, "R4", longint'(row_ready), 1);

    // R2 back-pressure against a full window
    @(negedge clk); wr_valid = 1'b1; wr_data = 16'hdead;
    repeat (3) begin
      @(negedge clk); #1;
      check(wr_ready == 1'b0, "R2", longint'(wr_ready), 0);
    end
    wr_valid = 1'b0;

    // R6 / R7 shifts with refills
    for (int s = 0; s < 4; s++) begin
      saved = win[1];
      do_shift();
      #1;
      exp_w = row_word(saved);
      check(rd_data[WW-1:0] == exp_w, "R6", longint'(rd_data[WW-1:0]), longint'(exp_w));
      check(row_ready == 1'b0 && wr_ready == 1'b1, "R6", longint'({row_ready, wr_ready}), 1);
      check(rd_active[2] == 1'b0 && rd_data[2*WW +: WW] == '0, "R7",
            longint'(rd_data[2*WW +: WW]), 0);
      send_row(10 + s, s % 3);
    end

    // R9 shift during refill is ignored
    do_shift();
    #1;
    act_before = rd_active;
    do_shift();
    #1;
    check(rd_active == act_before && row_ready == 1'b0, "R9", longint'(rd_active), longint'(act_before));
    send_row(20, 0);
    #1;
    check(row_ready == 1'b1 && rd_active == 7'b0000111, "R9", longint'(rd_active), 7);

    // height 7: full load and wrapping shifts
    @(negedge clk); cfg_height = 3'd7;
    for (int k = 0; k < 7; k++) send_row(30 + k, k % 2);
    #1;
    check(rd_active == 7'h7f, "R3", longint'(rd_active), 16'h7f);
    for (int s = 0; s < 9; s++) begin
      do_shift();
      send_row(40 + s, 0);
    end

    // R10 height change mid-refill restarts the load
    do_shift();
    @(negedge clk); cfg_height = 3'd5;
    @(negedge clk); #1;
    check(rd_active == '0 && wr_ready == 1'b1, "R10", longint'(rd_active), 0);
    for (int k = 0; k < 5; k++) send_row(60 + k, 1);
    for (int s = 0; s < 3; s++) begin
      do_shift();
      send_row(70 + s, 0);
    end
    #1;
    check(rd_active == 7'b0011111, "R8", longint'(rd_active), 16'h1f);

    // R10 zero acts as one, R12 single-row shift
    @(negedge clk); cfg_height = 3'd0;
    send_row(80, 0);
    #1;
    check(rd_active == 7'b0000001 && row_ready == 1'b1, "R10", longint'(rd_active), 1);
    do_shift();
    #1;
    check(rd_active == '0 && rd_data == '0, "R12", longint'(rd_active), 0);
    send_row(81, 0);
    #1;
    exp_w = (int'(rd_col) < RL) ? pix(81, int'(rd_col)) : '0;
    check(rd_data[WW-1:0] == exp_w, "R12", longint'(rd_data[WW-1:0]), longint'(exp_w));

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule